// File: doc/BRIEF.md
# Montgomery Ladder Scalar Multiplication Sequencer

This block computes Q = k·P for an elliptic-curve point P and a scalar k. It scans the scalar from its top bit down to bit 0 using ladder ordering. Each bit costs exactly one point addition and one point doubling, so the amount of work does not depend on the value of the scalar. The block does no point arithmetic itself. It holds two working points, R0 and R1, and sends operands to external add and double units through request/acknowledge handshakes. It then writes the returned results back into R0 and R1, choosing the destinations according to the current scalar bit.

A mode input picks the field. Mode 0 selects the binary-field unit pair (unit index 0) and a 163-bit scalar. Mode 1 selects the prime-field unit pair (unit index 1) and a 192-bit scalar. A point is an opaque vector whose most significant bit marks the point at infinity; the lower bits carry the coordinates and are never interpreted here.

The sequencer has five states. IDLE waits for start. When start arrives it latches k and the mode, loads R0 with infinity and R1 with P, and moves to ISSUE. ISSUE raises both requests for one bit and moves to WAIT. WAIT stays until both units have acknowledged, then moves to COMMIT. COMMIT writes both results back. From COMMIT the sequencer goes to ISSUE if bits remain, or to FINISH after bit 0. FINISH pulses done and returns to IDLE.

Top module: `ml_ladder_top`

## Requirements
- R1: After reset, done is low, no add or double request is raised, and result_inf is 1.
- R2: A start accepted in IDLE sets R0 to the point at infinity (MSB set) and R1 to base_pt.
- R3: The sequencer visits bits 162 down to 0 of scalar in mode 0 and bits 191 down to 0 in mode 1. In mode 0, scalar bits 191..163 have no effect on the result.
- R4: For the current bit b, add_opa carries R(1-b), add_opb carries R(b) and dbl_op carries R(b). At COMMIT the sum goes to R(1-b) and the doubled value goes to R(b), so both results come from values taken before the iteration.
- R5: For every bit, whatever its value, one add and one double are requested in the same cycle. A run therefore makes exactly 163 (mode 0) or 192 (mode 1) requests of each kind.
- R6: A request stays high until its acknowledge arrives. The next bit is not issued until both units have acknowledged the current one.
- R7: Mode 0 drives only request index 0 and mode 1 drives only request index 1. The request of the other index stays low for the whole run.
- R8: done is high for exactly one cycle, the cycle after the COMMIT of bit 0. At that point result equals the final R0, i.e. k·P.
- R9: When k·P is the point at infinity (for example k = 0), result_inf is 1 when done is high.
- R10: A start that arrives while a run is in progress is ignored. The run finishes with the values latched at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiplication (taken only in IDLE) |
| mode | input | 1 | 0 = binary field, 1 = prime field |
| scalar | input | KW | Scalar k |
| base_pt | input | PW | Point P; MSB is the infinity flag |
| done | output | 1 | One-cycle completion pulse |
| result | output | PW | Current R0; equals k·P when done is high |
| result_inf | output | 1 | Infinity flag of result |
| add_req | output | 2 | Add request, one bit per field unit |
| add_ack | input | 2 | Add acknowledge, result valid in the same cycle |
| add_opa | output | PW | Add operand R(1-b) |
| add_opb | output | PW | Add operand R(b) |
| add_sum | input | 2×PW | Add results, one per field unit |
| dbl_req | output | 2 | Double request, one bit per field unit |
| dbl_ack | input | 2 | Double acknowledge, result valid in the same cycle |
| dbl_op | output | PW | Double operand R(b) |
| dbl_out | input | 2×PW | Double results, one per field unit |

## Verification
The assertions assume that every unit answers each request with one acknowledge pulse, and that no unit acknowledges while its request is low. The bench's unit models follow this rule: each waits a configurable latency after seeing a request, raises its acknowledge for a single cycle, and then waits for the request to drop before it accepts another. The models compute over the integers modulo 1009, so k·P can be predicted independently as (k mod 1009)·x. The add and double latencies differ between vectors, which exercises both acknowledge orders.

// File: rtl/ml_ladder_pkg.sv
package ml_ladder_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_COMMIT,
        ST_FINISH
    } ladder_state_e;

    localparam int NUM_FIELDS = 2;
    localparam int FLD_BIN    = 0;
    localparam int FLD_PRM    = 1;

endpackage

// File: rtl/ml_ladder_seq.sv
module ml_ladder_seq
    import ml_ladder_pkg::*;
#(
    parameter int KW       = 192,
    parameter int KLEN_BIN = 163,
    parameter int KLEN_PRM = 192
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode,
    input  logic [KW-1:0] scalar,
    input  logic          pair_done,
    output logic          init_pts,
    output logic          issue,
    output logic          commit,
    output logic          done,
    output logic          cur_bit,
    output logic          fld_sel
);

    localparam int IW = $clog2(KW);

    ladder_state_e state, nxt;
    logic [KW-1:0] k_q;
    logic [IW-1:0] idx;
    logic          last_bit;

    assign last_bit = (idx == '0);
    assign cur_bit  = k_q[idx];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_ISSUE;
            ST_ISSUE:  nxt = ST_WAIT;
            ST_WAIT:   if (pair_done) nxt = ST_COMMIT;
            ST_COMMIT: nxt = last_bit ? ST_FINISH : ST_ISSUE;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // scalar, field and bit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q     <= '0;
            fld_sel <= 1'b0;
            idx     <= '0;
        end else if (state == ST_IDLE && start) begin
            k_q     <= scalar;
            fld_sel <= mode;
            idx     <= mode ? IW'(KLEN_PRM - 1) : IW'(KLEN_BIN - 1);
        end else if (state == ST_COMMIT && !last_bit) begin
            idx     <= idx - 1'b1;
        end
    end

    // outputs
    always_comb begin
        init_pts = 1'b0;
        issue    = 1'b0;
        commit   = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:   init_pts = start;
            ST_ISSUE:  issue    = 1'b1;
            ST_WAIT:   ;
            ST_COMMIT: commit   = 1'b1;
            ST_FINISH: done     = 1'b1;
            default:   ;
        endcase
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_commit_after_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(pair_done));

    p_index_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (fld_sel ? (int'(idx) < KLEN_PRM) : (int'(idx) < KLEN_BIN)));

endmodule

// File: rtl/ml_ladder_ops.sv
module ml_ladder_ops
    import ml_ladder_pkg::*;
#(
    parameter int PW = 577
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           issue,
    input  logic                           fld_sel,
    input  logic [NUM_FIELDS-1:0]          add_ack,
    input  logic [NUM_FIELDS-1:0][PW-1:0]  add_sum,
    input  logic [NUM_FIELDS-1:0]          dbl_ack,
    input  logic [NUM_FIELDS-1:0][PW-1:0]  dbl_out,
    output logic [NUM_FIELDS-1:0]          add_req,
    output logic [NUM_FIELDS-1:0]          dbl_req,
    output logic [PW-1:0]                  sum_q,
    output logic [PW-1:0]                  dbl_q,
    output logic                           pair_done
);

    logic add_got, dbl_got;
    logic add_hit, dbl_hit;

    assign add_hit   = add_req[fld_sel] && add_ack[fld_sel];
    assign dbl_hit   = dbl_req[fld_sel] && dbl_ack[fld_sel];
    assign pair_done = add_got && dbl_got;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_unit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                add_req[f] <= 1'b0;
                dbl_req[f] <= 1'b0;
            end else begin
                if (issue && int'(fld_sel) == f) add_req[f] <= 1'b1;
                else if (add_ack[f])             add_req[f] <= 1'b0;
                if (issue && int'(fld_sel) == f) dbl_req[f] <= 1'b1;
                else if (dbl_ack[f])             dbl_req[f] <= 1'b0;
            end
        end

        p_add_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (add_req[f] && !add_ack[f]) |=> add_req[f]);

        p_dbl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (dbl_req[f] && !dbl_ack[f]) |=> dbl_req[f]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            add_got <= 1'b0;
            dbl_got <= 1'b0;
            sum_q   <= '0;
            dbl_q   <= '0;
        end else begin
            if (issue) begin
                add_got <= 1'b0;
                dbl_got <= 1'b0;
            end else begin
                if (add_hit) begin
                    add_got <= 1'b1;
                    sum_q   <= add_sum[fld_sel];
                end
                if (dbl_hit) begin
                    dbl_got <= 1'b1;
                    dbl_q   <= dbl_out[fld_sel];
                end
            end
        end
    end

    p_field_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !add_req[!fld_sel] && !dbl_req[!fld_sel]);

    p_req_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(add_req) && $onehot0(dbl_req));

endmodule

// File: rtl/ml_ladder_pts.sv
module ml_ladder_pts #(
    parameter int PW = 577
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_pts,
    input  logic [PW-1:0] base_pt,
    input  logic          commit,
    input  logic          cur_bit,
    input  logic [PW-1:0] sum_in,
    input  logic [PW-1:0] dbl_in,
    output logic [PW-1:0] opa,
    output logic [PW-1:0] opb,
    output logic [PW-1:0] r0_o
);

    localparam logic [PW-1:0] PT_INF = {1'b1, {(PW-1){1'b0}}};

    logic [PW-1:0] r0, r1;

    // R(1-b) and R(b)
    assign opa  = cur_bit ? r0 : r1;
    assign opb  = cur_bit ? r1 : r0;
    assign r0_o = r0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r0 <= PT_INF;
            r1 <= '0;
        end else if (init_pts) begin
            r0 <= PT_INF;
            r1 <= base_pt;
        end else if (commit) begin
            if (cur_bit) begin
                r0 <= sum_in;
                r1 <= dbl_in;
            end else begin
                r0 <= dbl_in;
                r1 <= sum_in;
            end
        end
    end

    p_init_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_pts |=> r0[PW-1] && (r1 == $past(base_pt)));

    p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_pts && !commit) |=> ($stable(r0) && $stable(r1)));

endmodule

// File: rtl/ml_ladder_top.sv
module ml_ladder_top
    import ml_ladder_pkg::*;
#(
    parameter int CW       = 192,
    parameter int KW       = 192,
    parameter int KLEN_BIN = 163,
    parameter int KLEN_PRM = 192,
    localparam int PW      = 1 + 3 * CW
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          mode,
    input  logic [KW-1:0]                 scalar,
    input  logic [PW-1:0]                 base_pt,
    output logic                          done,
    output logic [PW-1:0]                 result,
    output logic                          result_inf,
    output logic [NUM_FIELDS-1:0]         add_req,
    input  logic [NUM_FIELDS-1:0]         add_ack,
    output logic [PW-1:0]                 add_opa,
    output logic [PW-1:0]                 add_opb,
    input  logic [NUM_FIELDS-1:0][PW-1:0] add_sum,
    output logic [NUM_FIELDS-1:0]         dbl_req,
    input  logic [NUM_FIELDS-1:0]         dbl_ack,
    output logic [PW-1:0]                 dbl_op,
    input  logic [NUM_FIELDS-1:0][PW-1:0] dbl_out
);

    logic          init_pts, issue, commit, cur_bit, fld_sel, pair_done;
    logic [PW-1:0] sum_q, dbl_q;

    ml_ladder_seq #(
        .KW(KW), .KLEN_BIN(KLEN_BIN), .KLEN_PRM(KLEN_PRM)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .scalar(scalar),
        .pair_done(pair_done), .init_pts(init_pts), .issue(issue),
        .commit(commit), .done(done), .cur_bit(cur_bit), .fld_sel(fld_sel)
    );

    ml_ladder_ops #(.PW(PW)) u_ops (
        .clk(clk), .rst_n(rst_n), .issue(issue), .fld_sel(fld_sel),
        .add_ack(add_ack), .add_sum(add_sum), .dbl_ack(dbl_ack), .dbl_out(dbl_out),
        .add_req(add_req), .dbl_req(dbl_req), .sum_q(sum_q), .dbl_q(dbl_q),
        .pair_done(pair_done)
    );

    ml_ladder_pts #(.PW(PW)) u_pts (
        .clk(clk), .rst_n(rst_n), .init_pts(init_pts), .base_pt(base_pt),
        .commit(commit), .cur_bit(cur_bit), .sum_in(sum_q), .dbl_in(dbl_q),
        .opa(add_opa), .opb(add_opb), .r0_o(result)
    );

    assign dbl_op     = add_opb;
    assign result_inf = result[PW-1];

    p_pair_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|add_req) |-> $rose(|dbl_req));

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (add_req == '0) && (dbl_req == '0));

endmodule

// File: tb/ml_ladder_top_tb.sv
`timescale 1ns/1ps
module ml_ladder_top_tb;

    localparam int CW = 192;
    localparam int KW = 192;
    localparam int PW = 1 + 3 * CW;
    localparam int M  = 1009;
    localparam int NV = 8;

    localparam logic [KW-1:0] T_K [NV] = '{
        192'h1,
        192'h3,
        {48{4'hF}},
        192'hFFFFFFFF_00000000_00000000_00000000_00000000_0000ABCD,
        {1'b1, 191'h0},
        {24{8'h5A}},
        192'h123456789ABCDEF0_0FEDCBA987654321_1122334455667788,
        192'd1009
    };
    localparam bit T_MODE [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam int T_X   [NV] = '{5, 7, 123, 44, 11, 1008, 77, 3};
    localparam int T_AL  [NV] = '{1, 2, 4, 1, 3, 1, 2, 5};
    localparam int T_DL  [NV] = '{1, 5, 1, 3, 3, 3, 2, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic [KW-1:0] scalar = '0;
    logic [PW-1:0] base_pt = '0;
    logic done, result_inf;
    logic [PW-1:0] result, add_opa, add_opb, dbl_op;
    logic [1:0] add_req, dbl_req;
    logic [1:0] add_ack = 2'b00;
    logic [1:0] dbl_ack = 2'b00;
    logic [1:0][PW-1:0] add_sum = '0;
    logic [1:0][PW-1:0] dbl_out = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int add_lat = 1, dbl_lat = 1;
    int a_cnt [2] = '{0, 0};
    int d_cnt [2] = '{0, 0};

    // monitor state
    logic [KW-1:0] cur_k = '0;
    int  cur_len = 192;
    int  cur_x = 1;
    int  cur_fld = 1;
    int  add_rises = 0, dbl_rises = 0, other_rises = 0, op_err = 0, done_cnt = 0;
    logic [1:0] add_prev = 2'b00, dbl_prev = 2'b00;

    always #2.5 clk = ~clk;

    ml_ladder_top #(.CW(CW), .KW(KW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .scalar(scalar),
        .base_pt(base_pt), .done(done), .result(result), .result_inf(result_inf),
        .add_req(add_req), .add_ack(add_ack), .add_opa(add_opa), .add_opb(add_opb),
        .add_sum(add_sum), .dbl_req(dbl_req), .dbl_ack(dbl_ack), .dbl_op(dbl_op),
        .dbl_out(dbl_out)
    );

    function automatic int pval(input logic [PW-1:0] p);
        return p[PW-1] ? 0 : int'(p[15:0]) % M;
    endfunction

    function automatic logic [PW-1:0] mkpt(input int v);
        logic [PW-1:0] p = '0;
        if (v == 0) p[PW-1] = 1'b1;
        else        p[15:0] = 16'(v);
        return p;
    endfunction

    function automatic int expect_val(input logic [KW-1:0] k, input int len, input int x);
        longint e = 0;
        for (int i = len - 1; i >= 0; i--) e = (2 * e + longint'(k[i])) % M;
        return int'((e * x) % M);
    endfunction

    // behavioural units over integers mod M
    always @(posedge clk) begin
        for (int f = 0; f < 2; f++) begin
            if (add_ack[f]) add_ack[f] <= 1'b0;
            else if (a_cnt[f] > 0) begin
                if (a_cnt[f] == 1) begin
                    add_ack[f] <= 1'b1;
                    add_sum[f] <= mkpt((pval(add_opa) + pval(add_opb)) % M);
                end
                a_cnt[f] <= a_cnt[f] - 1;
            end else if (add_req[f]) a_cnt[f] <= add_lat;

            if (dbl_ack[f]) dbl_ack[f] <= 1'b0;
            else if (d_cnt[f] > 0) begin
                if (d_cnt[f] == 1) begin
                    dbl_ack[f] <= 1'b1;
                    dbl_out[f] <= mkpt((2 * pval(dbl_op)) % M);
                end
                d_cnt[f] <= d_cnt[f] - 1;
            end else if (dbl_req[f]) d_cnt[f] <= dbl_lat;
        end
    end

    // request monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            for (int f = 0; f < 2; f++) begin
                if (dbl_req[f] && !dbl_prev[f] && f == cur_fld) dbl_rises++;
                if (add_req[f] && !add_prev[f]) begin
                    if (f != cur_fld) other_rises++;
                    else begin
                        int pos;
                        int d;
                        int ex;
                        pos = cur_len - 1 - add_rises;
                        if (pos >= 0) begin
                            d  = (pval(add_opa) - pval(add_opb) + M) % M;
                            ex = cur_k[pos] ? (M - cur_x) % M : cur_x % M;
                            if (d != ex) op_err++;
                        end
                        if (dbl_op != add_opb) op_err++;
                        if (!(dbl_req[f] && !dbl_prev[f])) op_err++;
                        add_rises++;
                    end
                end
                if (dbl_req[f] && !dbl_prev[f] && !(add_req[f] && !add_prev[f])) op_err++;
            end
            add_prev <= add_req;
            dbl_prev <= dbl_req;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic prep(input bit md, input logic [KW-1:0] k, input int x, input int al, input int dl);
        cur_k = k; cur_len = md ? 192 : 163; cur_x = x; cur_fld = md ? 1 : 0;
        add_lat = al; dbl_lat = dl;
        add_rises = 0; dbl_rises = 0; other_rises = 0; op_err = 0; done_cnt = 0;
    endtask

    task automatic wait_done(output bit got, output int rv, output bit rinf);
        got = 0; rv = 0; rinf = 0;
        for (int c = 0; c < 20000 && !got; c++) begin
            @(negedge clk);
            if (done) begin got = 1; rv = pval(result); rinf = result_inf; end
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic run_vec(input bit md, input logic [KW-1:0] k, input int x, input int al, input int dl);
        bit got, rinf;
        int rv, ev;
        prep(md, k, x, al, dl);
        @(negedge clk);
        mode = md; scalar = k; base_pt = mkpt(x); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(got, rv, rinf);
        ev = expect_val(k, cur_len, x);
        chk(got, "R8 done seen", longint'(got), 1);
        chk(rv == ev, "R3/R4 result value", rv, ev);
        chk(rinf == (ev == 0), "R9 result_inf", rinf, (ev == 0));
        chk(add_rises == cur_len, "R5 add count", add_rises, cur_len);
        chk(dbl_rises == cur_len, "R5 dbl count", dbl_rises, cur_len);
        chk(op_err == 0, "R4 operand routing / R5 pairing", op_err, 0);
        chk(other_rises == 0, "R7 other field idle", other_rises, 0);
        chk(done_cnt == 1, "R8 done width", done_cnt, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit got, rinf;
        int rv, ev;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1 done low", done, 0);
        chk(add_req == 2'b00 && dbl_req == 2'b00, "R1 no requests", {add_req, dbl_req}, 0);
        chk(result_inf == 1'b1, "R1 result_inf", result_inf, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(result_inf == 1'b1 && add_req == 2'b00, "R1 idle after reset", result_inf, 1);

        for (int v = 0; v < NV; v++)
            run_vec(T_MODE[v], T_K[v], T_X[v], T_AL[v], T_DL[v]);

        // R9 k = 0 in each mode
        run_vec(1'b1, '0, 321, 2, 1);
        run_vec(1'b0, '0, 9, 1, 2);

        // R3 binary mode ignores bits above 162
        run_vec(1'b0, {29'h1FFFFFFF, 163'h5}, 17, 1, 1);
        chk(pval(result) == (5 * 17) % M, "R3 upper bits ignored", pval(result), (5 * 17) % M);

        // R2: second run starts from fresh R0/R1 regardless of previous result
        run_vec(1'b1, 192'h2, 100, 1, 1);
        chk(pval(result) == 200, "R2 fresh init", pval(result), 200);

        // R10 start during a run is ignored
        prep(1'b1, 192'hABCDEF, 29, 2, 3);
        @(negedge clk);
        mode = 1'b1; scalar = 192'hABCDEF; base_pt = mkpt(29); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        mode = 1'b0; scalar = 192'h7; base_pt = mkpt(500); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(got, rv, rinf);
        ev = expect_val(192'hABCDEF, 192, 29);
        chk(rv == ev, "R10 result unaffected", rv, ev);
        chk(add_rises == 192, "R10 no restart", add_rises, 192);
        chk(other_rises == 0, "R10/R7 field unchanged", other_rises, 0);
        repeat (30) @(negedge clk);
        chk(done_cnt == 1, "R10 no second done", done_cnt, 1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule